// File: doc/BRIEF.md
# Job Ring Submission/Completion Controller

This block keeps the bookkeeping for one pair of descriptor rings: an inbound ring into which software places job descriptors, and an outbound ring into which finished descriptors are returned. Software programs the two ring base addresses and the ring size while the ring is stopped, then sets the run bit. After that, it reads the count of free inbound slots, fills that many descriptors at most, and announces them with a single write that carries a job count. Collected completions are released the same way, with one write that carries a count.

The controller hands the oldest outstanding inbound slot to a job engine. The engine is modelled here by a one-cycle completion strobe. Each accepted completion returns one inbound slot, takes one outbound slot, and names the outbound index where the finished descriptor goes. Ring indices wrap at the programmed power-of-two size. A level interrupt reports completions and count errors until software clears it with a write-one-to-clear.

Top module: `jr_ring_ctrl`

## Requirements
- R1: After reset the run bit is 0, the size register reads MAX_LOG2, the free-inbound count equals 2**MAX_LOG2, the full-outbound count is 0, `irq` is low and `job_req` is low.
- R2: While running, a write of N to the add register (address 5) lowers the free-inbound count (address 4) by N when N does not exceed it.
- R3: An add write with N greater than the free-inbound count adds only the free count, leaves it at 0, and sets error-detail bit 0 (address 9) and interrupt-status bit 1 (address 8).
- R4: A remove write (address 7) with N greater than the full-outbound count releases only the full count, leaves it at 0, and sets error-detail bit 1 and interrupt-status bit 1.
- R5: An accepted completion (`job_done` while `job_req`) raises `out_wr` in that cycle and moves one count from the inbound ring to the full-outbound count (address 6) at the next edge.
- R6: Inbound slots are consumed in order, and completions fill outbound slots in order. Both indices advance by one per completion and wrap to 0 at the programmed ring size. `out_wr_src` names the inbound slot being retired.
- R7: Each accepted completion sets interrupt-status bit 0. `irq` is the OR of the status bits and stays high until software clears it.
- R8: Writing the interrupt-status register clears each bit that is written as 1. Clearing bit 1 also clears both error-detail bits.
- R9: The base registers (addresses 1, 2) and the size register (address 3, log2 of the ring size, clamped to the range 1..MAX_LOG2) accept writes only while stopped. A size write empties both rings for the new size.
- R10: While stopped (address 0 bit 0 = 0), add and remove writes are ignored and `job_req` stays low.
- R11: `job_req` is low when the outbound ring is full, and a `job_done` strobe while `job_req` is low changes nothing.
- R12: While running, a remove write of N, where N does not exceed the full-outbound count, lowers that count by N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| job_req | output | 1 | Oldest inbound job is available to the engine |
| job_slot | output | MAX_LOG2 | Inbound index of that job |
| job_done | input | 1 | Engine completion strobe |
| out_wr | output | 1 | Finished descriptor is written this cycle |
| out_wr_slot | output | MAX_LOG2 | Outbound index receiving it |
| out_wr_src | output | MAX_LOG2 | Inbound index it came from |
| irq | output | 1 | Level interrupt |

## Verification
A wrong occupancy count shows up on the next register read of the free or full count, and it soon blocks or releases `job_req` at the wrong time. A stale or skipped index shows up on the very next completion, because `job_slot` and `out_wr_slot` break their strict ascending, wrapping sequence. A dropped status bit lowers `irq` before any clear write. Clamping errors appear in the error-detail register one edge after the oversized write.

// File: rtl/jr_pkg.sv
package jr_pkg;
  localparam int REG_AW = 4;

  localparam logic [REG_AW-1:0] RA_CMD      = 4'd0;
  localparam logic [REG_AW-1:0] RA_IN_BASE  = 4'd1;
  localparam logic [REG_AW-1:0] RA_OUT_BASE = 4'd2;
  localparam logic [REG_AW-1:0] RA_SIZE     = 4'd3;
  localparam logic [REG_AW-1:0] RA_IN_FREE  = 4'd4;
  localparam logic [REG_AW-1:0] RA_ADD      = 4'd5;
  localparam logic [REG_AW-1:0] RA_OUT_FULL = 4'd6;
  localparam logic [REG_AW-1:0] RA_DROP     = 4'd7;
  localparam logic [REG_AW-1:0] RA_IRQ      = 4'd8;
  localparam logic [REG_AW-1:0] RA_ERR      = 4'd9;

  localparam int IRQ_DONE_BIT = 0;
  localparam int IRQ_ERR_BIT  = 1;
  localparam int ERR_ADD_BIT  = 0;
  localparam int ERR_DROP_BIT = 1;

  // requested log2 ring size, forced into 1..lim
  function automatic int unsigned fit_log2(input int unsigned req, input int unsigned lim);
    if (req == 0) return 1;
    if (req > lim) return lim;
    return req;
  endfunction

  // amount actually granted from a count request against a level
  function automatic int unsigned grant_of(input int unsigned req, input int unsigned level);
    return (req > level) ? level : req;
  endfunction
endpackage

// File: rtl/jr_occ.sv
module jr_occ #(
  parameter int CNT_W   = 5,
  parameter int REQ_W   = 32,
  parameter int RST_VAL = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             take,
  input  logic [REQ_W-1:0] take_n,
  input  logic             give,
  output logic [CNT_W-1:0] level,
  output logic [CNT_W-1:0] granted,
  output logic             over
);
  always_comb begin
    over    = take && (take_n > REQ_W'(level));
    granted = take ? CNT_W'(jr_pkg::grant_of(int'(take_n), int'(level))) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    level <= CNT_W'(RST_VAL);
    else if (load) level <= load_val;
    else           level <= level - granted + CNT_W'(give);
  end
endmodule

// File: rtl/jr_ptr.sv
module jr_ptr #(
  parameter int IDX_W = 4,
  parameter int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [CNT_W-1:0] amount,
  input  logic [IDX_W-1:0] mask,
  output logic [IDX_W-1:0] idx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx <= '0;
    else if (clear) idx <= '0;
    else if (step)  idx <= IDX_W'((CNT_W'(idx) + amount) & CNT_W'(mask));
  end
endmodule

// File: rtl/jr_regs.sv
module jr_regs #(
  parameter int DATA_W   = 32,
  parameter int MAX_LOG2 = 4,
  parameter int LOG_W    = 3,
  parameter int CNT_W    = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic [jr_pkg::REG_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  input  logic [CNT_W-1:0]          free_lvl,
  input  logic [CNT_W-1:0]          full_lvl,
  input  logic                      done_evt,
  input  logic                      add_over,
  input  logic                      drop_over,
  output logic                      enable,
  output logic [LOG_W-1:0]          size_log2,
  output logic [LOG_W-1:0]          size_fit,
  output logic                      cfg_load,
  output logic                      add_wr,
  output logic                      drop_wr,
  output logic [1:0]                err_bits,
  output logic                      irq
);
  import jr_pkg::*;

  logic [DATA_W-1:0] in_base, out_base;
  logic              done_flag;
  logic              irq_wr;
  logic [1:0]        irq_stat;

  assign size_fit = LOG_W'(fit_log2(int'(bus_wdata[7:0]), MAX_LOG2));
  assign cfg_load = bus_wr && !enable && (bus_addr == RA_SIZE);
  assign add_wr   = bus_wr && enable && (bus_addr == RA_ADD);
  assign drop_wr  = bus_wr && enable && (bus_addr == RA_DROP);
  assign irq_wr   = bus_wr && (bus_addr == RA_IRQ);
  assign irq_stat = {|err_bits, done_flag};
  assign irq      = |irq_stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable    <= 1'b0;
      in_base   <= '0;
      out_base  <= '0;
      size_log2 <= LOG_W'(MAX_LOG2);
    end else if (bus_wr) begin
      if (bus_addr == RA_CMD) enable <= bus_wdata[0];
      if (!enable) begin
        if (bus_addr == RA_IN_BASE)  in_base   <= bus_wdata;
        if (bus_addr == RA_OUT_BASE) out_base  <= bus_wdata;
        if (bus_addr == RA_SIZE)     size_log2 <= size_fit;
      end
    end
  end

  // status: a new event in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_flag <= 1'b0;
      err_bits  <= '0;
    end else begin
      if (done_evt)                                   done_flag <= 1'b1;
      else if (irq_wr && bus_wdata[IRQ_DONE_BIT])     done_flag <= 1'b0;
      if (irq_wr && bus_wdata[IRQ_ERR_BIT])           err_bits  <= '0;
      if (add_over)                                   err_bits[ERR_ADD_BIT]  <= 1'b1;
      if (drop_over)                                  err_bits[ERR_DROP_BIT] <= 1'b1;
    end
  end

  always_comb begin
    unique case (bus_addr)
      RA_CMD:      bus_rdata = DATA_W'(enable);
      RA_IN_BASE:  bus_rdata = in_base;
      RA_OUT_BASE: bus_rdata = out_base;
      RA_SIZE:     bus_rdata = DATA_W'(size_log2);
      RA_IN_FREE:  bus_rdata = DATA_W'(free_lvl);
      RA_OUT_FULL: bus_rdata = DATA_W'(full_lvl);
      RA_IRQ:      bus_rdata = DATA_W'(irq_stat);
      RA_ERR:      bus_rdata = DATA_W'(err_bits);
      default:     bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/jr_ring_ctrl.sv
module jr_ring_ctrl #(
  parameter int DATA_W   = 32,
  parameter int MAX_LOG2 = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic [jr_pkg::REG_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  output logic                      job_req,
  output logic [MAX_LOG2-1:0]       job_slot,
  input  logic                      job_done,
  output logic                      out_wr,
  output logic [MAX_LOG2-1:0]       out_wr_slot,
  output logic [MAX_LOG2-1:0]       out_wr_src,
  output logic                      irq
);
  localparam int IDX_W  = MAX_LOG2;
  localparam int CNT_W  = MAX_LOG2 + 1;
  localparam int LOG_W  = $clog2(MAX_LOG2 + 1);
  localparam int NPTR   = 4;
  localparam int P_INP  = 0;
  localparam int P_INC  = 1;
  localparam int P_OUTP = 2;
  localparam int P_OUTC = 3;

  logic             enable, cfg_load, add_wr, drop_wr, accept;
  logic             add_over, drop_over;
  logic [LOG_W-1:0] size_log2, size_fit;
  logic [CNT_W-1:0] ring_size, load_size;
  logic [IDX_W-1:0] ring_mask;
  logic [CNT_W-1:0] free_lvl, full_lvl, add_grant, drop_grant;
  logic [1:0]       err_bits;

  logic             p_step [NPTR];
  logic [CNT_W-1:0] p_amt  [NPTR];
  logic [IDX_W-1:0] p_idx  [NPTR];

  assign ring_size = CNT_W'(1) << size_log2;
  assign load_size = CNT_W'(1) << size_fit;
  assign ring_mask = IDX_W'(ring_size - CNT_W'(1));

  assign job_req     = enable && (free_lvl != ring_size) && (full_lvl != ring_size);
  assign accept      = job_req && job_done;
  assign out_wr      = accept;
  assign job_slot    = p_idx[P_INC];
  assign out_wr_src  = p_idx[P_INC];
  assign out_wr_slot = p_idx[P_OUTP];

  jr_regs #(.DATA_W(DATA_W), .MAX_LOG2(MAX_LOG2), .LOG_W(LOG_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .free_lvl(free_lvl),
    .full_lvl(full_lvl), .done_evt(accept), .add_over(add_over),
    .drop_over(drop_over), .enable(enable), .size_log2(size_log2),
    .size_fit(size_fit), .cfg_load(cfg_load), .add_wr(add_wr),
    .drop_wr(drop_wr), .err_bits(err_bits), .irq(irq)
  );

  // free inbound slots: taken by add writes, returned by completions
  jr_occ #(.CNT_W(CNT_W), .REQ_W(DATA_W), .RST_VAL(1 << MAX_LOG2)) u_free (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .load_val(load_size),
    .take(add_wr), .take_n(bus_wdata), .give(accept),
    .level(free_lvl), .granted(add_grant), .over(add_over)
  );

  // full outbound slots: filled by completions, released by remove writes
  jr_occ #(.CNT_W(CNT_W), .REQ_W(DATA_W), .RST_VAL(0)) u_full (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .load_val('0),
    .take(drop_wr), .take_n(bus_wdata), .give(accept),
    .level(full_lvl), .granted(drop_grant), .over(drop_over)
  );

  assign p_step[P_INP]  = add_wr;
  assign p_amt[P_INP]   = add_grant;
  assign p_step[P_INC]  = accept;
  assign p_amt[P_INC]   = CNT_W'(1);
  assign p_step[P_OUTP] = accept;
  assign p_amt[P_OUTP]  = CNT_W'(1);
  assign p_step[P_OUTC] = drop_wr;
  assign p_amt[P_OUTC]  = drop_grant;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    jr_ptr #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .clear(cfg_load), .step(p_step[g]),
      .amount(p_amt[g]), .mask(ring_mask), .idx(p_idx[g])
    );
  end
endmodule

// File: rtl/jr_ring_ctrl_chk.sv
module jr_ring_ctrl_chk #(
  parameter int DATA_W   = 32,
  parameter int MAX_LOG2 = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_wr,
  input logic [3:0]            bus_addr,
  input logic [DATA_W-1:0]     bus_wdata,
  input logic                  enable,
  input logic                  job_req,
  input logic [MAX_LOG2-1:0]   job_slot,
  input logic                  out_wr,
  input logic [MAX_LOG2-1:0]   ring_mask,
  input logic [MAX_LOG2:0]     ring_size,
  input logic [MAX_LOG2:0]     free_lvl,
  input logic [MAX_LOG2:0]     full_lvl,
  input logic [1:0]            err_bits,
  input logic                  irq
);
  p_free_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    free_lvl <= ring_size);

  p_add_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'd5 && enable && bus_wdata > DATA_W'(free_lvl)) |=> err_bits[0]);

  p_drop_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'd7 && enable && bus_wdata > DATA_W'(full_lvl)) |=> err_bits[1]);

  p_done_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_wr && !bus_wr) |=> full_lvl == $past(full_lvl) + 1'b1);

  p_in_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr |=> job_slot == (($past(job_slot) + 1'b1) & ring_mask));

  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(bus_wr && bus_addr == 4'd8)) |=> irq);

  p_stopped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !out_wr);

  p_req_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    job_req |-> (full_lvl < ring_size && free_lvl < ring_size));
endmodule

bind jr_ring_ctrl jr_ring_ctrl_chk #(.DATA_W(DATA_W), .MAX_LOG2(MAX_LOG2)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .enable(enable), .job_req(job_req),
  .job_slot(job_slot), .out_wr(out_wr), .ring_mask(ring_mask),
  .ring_size(ring_size), .free_lvl(free_lvl), .full_lvl(full_lvl),
  .err_bits(err_bits), .irq(irq)
);

// File: tb/jr_ring_ctrl_tb.sv
module jr_ring_ctrl_tb;
  localparam int DATA_W = 32;
  localparam int ML     = 4;
  localparam int VN     = 43;
  // entry: {kind, req tag, addr, data}; kind 0 write, 1 read-check, 2 done pulse
  localparam logic [47:0] VEC [VN] = '{
    {4'd0, 4'd9, 8'd1, 32'h1000}, {4'd0, 4'd9, 8'd2, 32'h2000},
    {4'd1, 4'd9, 8'd1, 32'h1000}, {4'd1, 4'd9, 8'd2, 32'h2000},
    {4'd0, 4'd9, 8'd3, 32'd2},    {4'd1, 4'd9, 8'd3, 32'd2},
    {4'd1, 4'd9, 8'd4, 32'd4},    {4'd0, 4'd10, 8'd5, 32'd2},
    {4'd1, 4'd10, 8'd4, 32'd4},   {4'd0, 4'd10, 8'd0, 32'd1},
    {4'd1, 4'd10, 8'd0, 32'd1},   {4'd0, 4'd2, 8'd5, 32'd3},
    {4'd1, 4'd2, 8'd4, 32'd1},    {4'd0, 4'd9, 8'd3, 32'd0},
    {4'd1, 4'd9, 8'd3, 32'd2},    {4'd2, 4'd5, 8'd0, 32'd0},
    {4'd1, 4'd5, 8'd4, 32'd2},    {4'd1, 4'd5, 8'd6, 32'd1},
    {4'd1, 4'd7, 8'd8, 32'd1},    {4'd0, 4'd7, 8'd8, 32'd1},
    {4'd1, 4'd7, 8'd8, 32'd0},    {4'd0, 4'd3, 8'd5, 32'd5},
    {4'd1, 4'd3, 8'd4, 32'd0},    {4'd1, 4'd3, 8'd9, 32'd1},
    {4'd1, 4'd3, 8'd8, 32'd2},    {4'd0, 4'd8, 8'd8, 32'd2},
    {4'd1, 4'd8, 8'd9, 32'd0},    {4'd1, 4'd8, 8'd8, 32'd0},
    {4'd0, 4'd4, 8'd7, 32'd3},    {4'd1, 4'd4, 8'd6, 32'd0},
    {4'd1, 4'd4, 8'd9, 32'd2},    {4'd0, 4'd8, 8'd8, 32'd2},
    {4'd2, 4'd5, 8'd0, 32'd0},    {4'd2, 4'd5, 8'd0, 32'd0},
    {4'd2, 4'd5, 8'd0, 32'd0},    {4'd2, 4'd5, 8'd0, 32'd0},
    {4'd1, 4'd11, 8'd6, 32'd4},   {4'd1, 4'd11, 8'd4, 32'd4},
    {4'd0, 4'd12, 8'd7, 32'd2},   {4'd1, 4'd12, 8'd6, 32'd2},
    {4'd1, 4'd7, 8'd8, 32'd1},    {4'd0, 4'd7, 8'd8, 32'd1},
    {4'd1, 4'd7, 8'd8, 32'd0}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0;
  logic [3:0]        bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              job_req, job_done = 1'b0, out_wr, irq;
  logic [ML-1:0]     job_slot, out_wr_slot, out_wr_src;
  int                total = 0, bad = 0;

  always #5 clk = ~clk;

  jr_ring_ctrl #(.DATA_W(DATA_W), .MAX_LOG2(ML)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .job_req(job_req),
    .job_slot(job_slot), .job_done(job_done), .out_wr(out_wr),
    .out_wr_slot(out_wr_slot), .out_wr_src(out_wr_src), .irq(irq)
  );

  task automatic check(input int tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int tag, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1 check(tag, bus_rdata, exp);
  endtask

  task automatic pulse();
    @(negedge clk);
    job_done = 1'b1;
    @(negedge clk);
    job_done = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [47:0] v;
    int ein, eout;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    rd(1, 4'd0, 0); rd(1, 4'd3, ML); rd(1, 4'd4, 16); rd(1, 4'd6, 0);
    check(1, irq, 0); check(1, job_req, 0);

    // table: R2 R3 R4 R5 R7 R8 R9 R10 R11 R12
    for (int i = 0; i < VN; i++) begin
      v = VEC[i];
      case (v[47:44])
        4'd0:    wr(v[35:32], v[31:0]);
        4'd1:    rd(int'(v[43:40]), v[35:32], v[31:0]);
        default: pulse();
      endcase
    end

    // R6: in-order completion with wrap at size 4 (pointers are now in 1, out 1)
    wr(4'd7, 2);
    wr(4'd5, 4);
    ein = 1; eout = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(6, job_req, 1);
      check(6, job_slot, ein);
      job_done = 1'b1;
      #1;
      check(5, out_wr, 1);
      check(6, out_wr_slot, eout);
      check(6, out_wr_src, ein);
      @(negedge clk);
      job_done = 1'b0;
      ein = (ein + 1) % 4; eout = (eout + 1) % 4;
    end

    // R11: outbound full blocks the engine and stray strobes
    @(negedge clk);
    check(11, job_req, 0);
    job_done = 1'b1;
    #1 check(11, out_wr, 0);
    @(negedge clk);
    job_done = 1'b0;
    rd(11, 4'd6, 4); rd(11, 4'd4, 4);

    // R10: stopped ring ignores remove writes
    wr(4'd0, 0);
    wr(4'd7, 1);
    rd(10, 4'd6, 4);
    check(10, job_req, 0);

    // R7 and R8: level interrupt until write-one-to-clear
    check(7, irq, 1);
    wr(4'd8, 3);
    #1 check(8, irq, 0);

    // R9: size clamp and ring reset on size write
    wr(4'd3, 9);
    rd(9, 4'd3, ML); rd(9, 4'd4, 16); rd(9, 4'd6, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule